// File: doc/BRIEF.md
# Dual-Processor Mailbox Doorbell Controller

The block lets two processors, called side A and side B, signal each other. It holds two 32-bit message words that either side can use to pass data. It also holds four doorbell flags. Side A owns the flags X1 and X2, and side B owns the flags Y1 and Y2. Each side has its own control word. Through that word a side writes its own flags directly. It sees the peer's flags and can only clear them, by writing a 1. It also chooses which of the peer's flags raise its own interrupt.

All access goes through one register port. Each request carries a requester bit that names the side making it. Side B may reach all four words. Side A cannot reach the B-side control word. Reads return their data one cycle after the request. The two interrupt outputs are registered levels.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset, every register, flag and enable is zero, both interrupts are low and no read response is pending.
- R2: Word select is req_addr[3:2], and req_addr[1:0] is ignored. Index 0 is message word 1 and index 2 is message word 2. Both sides can write and read back any 32-bit value in either word, and writing one word does not touch the other.
- R3: The A-side control word is at index 1. Bit 0 is X1, bit 1 is Y2, bit 2 is Y1, bit 3 is X2, bit 4 enables Y1 onto irq_a and bit 5 enables Y2 onto irq_a.
- R4: The B-side control word is at index 3. Bit 0 is Y1, bit 1 is X2, bit 2 is X1, bit 3 is Y2, bit 4 enables X1 onto irq_b and bit 5 enables X2 onto irq_b.
- R5: A write to a control word copies the written value into that word's owned flags (X1 and X2 in the A-side word, Y1 and Y2 in the B-side word) and into its two enables, so the write can set or clear each of them.
- R6: A write to a control word clears each peer flag whose bit is 1. A 0 in that bit leaves the flag unchanged, and a write never sets a peer flag.
- R7: irq_a is high exactly when (Y1 and its enable) or (Y2 and its enable) holds, and irq_b likewise for X1 and X2. Both outputs are registered and change on the same clock edge as the write that causes the change.
- R8: req_src is 0 for side A and 1 for side B. When side A reads the B-side control word, the response is zero. When side A writes that word, nothing changes. Side B can read and write all four words.
- R9: Bits 31:6 of both control words read as zero and ignore writes.
- R10: A read request yields rsp_valid high for exactly one cycle, on the clock edge after the request, with the data as it stood when the request was made. A write request yields no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 1 | Requester: 0 = side A, 1 = side B |
| req_addr | input | 4 | Byte address; bits 3:2 select the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_a | output | 1 | Interrupt to side A |
| irq_b | output | 1 | Interrupt to side B |

## Verification
The doorbell function is exercised with the following write patterns, and each one separates a different fault:
- Owner writes that set flags and then clear them separate a flag that follows the write from one that merely latches.
- Peer writes with the clear bit at 1, and the same bit at 0, separate a true write-1-to-clear from a plain overwrite. A peer write to an already clear flag shows that the peer can never set it.
- Enable changes made while the flags are held expose a wrong flag-to-interrupt pairing.
- Side A's writes to the B-side word, and all-ones writes, show whether the block rejects accesses to a word that side A may not reach and masks off the upper bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    typedef enum logic [1:0] {
        REG_MSG1 = 2'd0,
        REG_CTLA = 2'd1,
        REG_MSG2 = 2'd2,
        REG_CTLB = 2'd3
    } reg_e;

    typedef struct packed {
        logic x1;
        logic x2;
        logic y1;
        logic y2;
    } bell_t;

    typedef struct packed {
        logic a_y1;
        logic a_y2;
        logic b_x1;
        logic b_x2;
    } irq_en_t;

    localparam int CTL_BITS = 6;
    localparam int IDX_LSB  = 2;
    localparam int NUM_MSG  = 2;

    // A-side view: owned flags at bits 0 and 3, peer flags at 1 and 2
    function automatic logic [CTL_BITS-1:0] ctla_view(bell_t b, irq_en_t e);
        return {e.a_y2, e.a_y1, b.x2, b.y1, b.y2, b.x1};
    endfunction

    // B-side view: the mirror image of the A-side view
    function automatic logic [CTL_BITS-1:0] ctlb_view(bell_t b, irq_en_t e);
        return {e.b_x2, e.b_x1, b.y2, b.x1, b.x2, b.y1};
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_src,
    input  logic [1:0] word_idx,
    output reg_e       sel,
    output logic       blocked,
    output logic       wr_en,
    output logic       rd_en
);

    always_comb begin
        sel     = reg_e'(word_idx);
        // Side A has no access to the B-side control word
        blocked = (sel == REG_CTLB) && (side_e'(req_src) == SIDE_A);
        wr_en   = req_valid && req_write && !blocked;
        rd_en   = req_valid && !req_write;
    end

endmodule

// File: rtl/mbx_bells.sv
module mbx_bells
    import mbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctla,
    input  logic                wr_ctlb,
    input  logic [CTL_BITS-1:0] wbits,
    output bell_t               bells_q,
    output irq_en_t             en_q,
    output logic                irq_a,
    output logic                irq_b
);

    typedef struct packed {
        bell_t   bells;
        irq_en_t en;
        logic    irq_a;
        logic    irq_b;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctla) begin
            st_d.bells.x1 = wbits[0];
            st_d.bells.x2 = wbits[3];
            if (wbits[1]) st_d.bells.y2 = 1'b0;
            if (wbits[2]) st_d.bells.y1 = 1'b0;
            st_d.en.a_y1  = wbits[4];
            st_d.en.a_y2  = wbits[5];
        end
        if (wr_ctlb) begin
            st_d.bells.y1 = wbits[0];
            st_d.bells.y2 = wbits[3];
            if (wbits[1]) st_d.bells.x2 = 1'b0;
            if (wbits[2]) st_d.bells.x1 = 1'b0;
            st_d.en.b_x1  = wbits[4];
            st_d.en.b_x2  = wbits[5];
        end
        st_d.irq_a = (st_d.bells.y1 && st_d.en.a_y1) || (st_d.bells.y2 && st_d.en.a_y2);
        st_d.irq_b = (st_d.bells.x1 && st_d.en.b_x1) || (st_d.bells.x2 && st_d.en.b_x2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bells_q = st_q.bells;
    assign en_q    = st_q.en;
    assign irq_a   = st_q.irq_a;
    assign irq_b   = st_q.irq_b;

endmodule

// File: rtl/mbx_msg_reg.sv
module mbx_msg_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q
);

    logic [DATA_W-1:0] value_d;

    always_comb begin
        value_d = wr ? wdata : value_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_a,
    output logic              irq_b
);

    localparam int PAD_W = DATA_W - CTL_BITS;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    reg_e    sel;
    logic    blocked, wr_en, rd_en;
    bell_t   bells_q;
    irq_en_t en_q;
    logic    unused_addr;
    logic    [NUM_MSG-1:0] msg_wr;
    logic    [DATA_W-1:0]  msg_q [NUM_MSG];
    rsp_t    rsp_d, rsp_q;

    assign unused_addr = ^req_addr;

    mbx_decode i_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_src   (req_src),
        .word_idx  (req_addr[IDX_LSB +: 2]),
        .sel       (sel),
        .blocked   (blocked),
        .wr_en     (wr_en),
        .rd_en     (rd_en)
    );

    mbx_bells i_bells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctla (wr_en && (sel == REG_CTLA)),
        .wr_ctlb (wr_en && (sel == REG_CTLB)),
        .wbits   (req_wdata[CTL_BITS-1:0]),
        .bells_q (bells_q),
        .en_q    (en_q),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );

    // message words sit at even word indices: 0 and 2
    for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg
        assign msg_wr[g] = wr_en && (sel == reg_e'(2 * g));
        mbx_msg_reg #(.DATA_W(DATA_W)) i_msg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (msg_wr[g]),
            .wdata   (req_wdata),
            .value_q (msg_q[g])
        );
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = rd_en;
        if (rd_en) begin
            unique case (sel)
                REG_MSG1: rsp_d.data = msg_q[0];
                REG_MSG2: rsp_d.data = msg_q[1];
                REG_CTLA: rsp_d.data = {{PAD_W{1'b0}}, ctla_view(bells_q, en_q)};
                REG_CTLB: rsp_d.data = blocked ? '0
                                     : {{PAD_W{1'b0}}, ctlb_view(bells_q, en_q)};
                default:  rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_src,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_a,
    input logic              irq_b,
    input bell_t             bells,
    input irq_en_t           en
);

    logic [1:0] idx;
    logic       a_req, b_req, unused_chk;
    assign idx        = req_addr[IDX_LSB +: 2];
    assign a_req      = req_valid && (req_src == 1'b0);
    assign b_req      = req_valid && (req_src == 1'b1);
    assign unused_chk = ^req_wdata;

    assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_rsp_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_blocked_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !req_write && idx == 2'd3) |=> (rsp_rdata == '0));

    assert_blocked_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && req_write && idx == 2'd3) |=> ($stable(bells) && $stable(en)));

    assert_w1c_zero_keeps_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && req_write && idx == 2'd3 && !req_wdata[1] && !req_wdata[2])
        |=> ($stable(bells.x1) && $stable(bells.x2)));

    assert_w1c_zero_keeps_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && idx == 2'd1 && !req_wdata[1] && !req_wdata[2])
        |=> ($stable(bells.y1) && $stable(bells.y2)));

    assert_w1c_clears_x1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && req_write && idx == 2'd3 && req_wdata[2]) |=> !bells.x1);

    assert_ctl_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr[IDX_LSB])) |-> (rsp_rdata[DATA_W-1:CTL_BITS] == '0));

    assert_irq_a_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en.a_y1 && !en.a_y2) |-> !irq_a);

    assert_irq_b_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (bells.x1 || bells.x2));

endmodule

bind mbx_doorbell mbx_doorbell_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_src   (req_src),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .bells     (bells_q),
    .en        (en_q)
);

// File: tb/test_mbx_doorbell.sv
module test_mbx_doorbell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_src = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_a, irq_b;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic        done    = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    localparam logic SA = 1'b0;
    localparam logic SB = 1'b1;

    always #4 clk = ~clk;

    mbx_doorbell i_mbx_doorbell (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_src   (req_src),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    task automatic wr(input logic src, input logic [3:0] addr, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_src = src; req_addr = addr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic src, input logic [3:0] addr, input logic [31:0] exp,
                      input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_src = src; req_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected response: actual %h expected none", rsp_rdata);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rsp_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_a at reset", irq_a, 1'b0);
        chk("R1 irq_b at reset", irq_b, 1'b0);
        rd(SA, 4'h4, 32'h0, "R1 ctla reset");
        rd(SB, 4'hC, 32'h0, "R1 ctlb reset");
        rd(SA, 4'h0, 32'h0, "R1 msg1 reset");
        rd(SB, 4'h8, 32'h0, "R1 msg2 reset");

        // R2 message words
        wr(SA, 4'h0, 32'hDEADBEEF);
        wr(SB, 4'h8, 32'h12345678);
        rd(SB, 4'h0, 32'hDEADBEEF, "R2 msg1 seen by B");
        rd(SA, 4'h8, 32'h12345678, "R2 msg2 seen by A");
        wr(SA, 4'h8, 32'hA5A50F0F);
        rd(SB, 4'h8, 32'hA5A50F0F, "R2 msg2 written by A");
        rd(SA, 4'h0, 32'hDEADBEEF, "R2 msg1 untouched");

        // R5 owner sets X1, X2; R3/R4 layouts
        wr(SA, 4'h4, 32'h09);
        rd(SA, 4'h4, 32'h09, "R3 ctla X1 X2");
        rd(SB, 4'hC, 32'h06, "R4 ctlb X1 bit2 X2 bit1");
        chk("R7 irq_b masked", irq_b, 1'b0);

        // B enables X interrupts, zero W1C bits keep flags
        wr(SB, 4'hC, 32'h30);
        chk("R7 irq_b enabled", irq_b, 1'b1);
        rd(SB, 4'hC, 32'h36, "R6 zero keeps X flags");

        // R6 peer clears X1 then X2
        wr(SB, 4'hC, 32'h34);
        chk("R7 irq_b from X2", irq_b, 1'b1);
        rd(SB, 4'hC, 32'h32, "R6 X1 cleared");
        rd(SA, 4'h4, 32'h08, "R6 ctla after X1 clear");
        wr(SB, 4'hC, 32'h32);
        chk("R7 irq_b after clears", irq_b, 1'b0);
        rd(SB, 4'hC, 32'h30, "R6 X2 cleared");

        // R6 peer cannot set
        wr(SB, 4'hC, 32'h36);
        rd(SA, 4'h4, 32'h00, "R6 peer cannot set X");
        chk("R7 irq_b stays low", irq_b, 1'b0);

        // B sets Y1, Y2 (R5), A views them (R3)
        wr(SB, 4'hC, 32'h39);
        rd(SA, 4'h4, 32'h06, "R3 ctla Y2 bit1 Y1 bit2");
        chk("R7 irq_a masked", irq_a, 1'b0);
        wr(SA, 4'h4, 32'h10);
        chk("R7 irq_a from Y1", irq_a, 1'b1);
        wr(SA, 4'h4, 32'h14);
        chk("R7 irq_a after Y1 clear", irq_a, 1'b0);
        rd(SA, 4'h4, 32'h12, "R6 Y1 cleared");
        rd(SB, 4'hC, 32'h38, "R4 ctlb Y2 bit3");
        wr(SA, 4'h4, 32'h20);
        chk("R7 irq_a from Y2", irq_a, 1'b1);

        // R8 side A locked out of ctlb
        wr(SA, 4'hC, 32'hFFFFFFFF);
        rd(SA, 4'hC, 32'h0, "R8 A read of ctlb");
        rd(SB, 4'hC, 32'h38, "R8 ctlb unchanged");
        chk("R8 irq_a unchanged", irq_a, 1'b1);
        chk("R8 irq_b unchanged", irq_b, 1'b0);
        rd(SB, 4'h4, 32'h22, "R8 B reads ctla");

        // R9 upper bits ignored
        wr(SA, 4'h4, 32'hFFFFFFC9);
        rd(SA, 4'h4, 32'h0B, "R9 upper bits zero");
        chk("R7 irq_a enables off", irq_a, 1'b0);
        chk("R7 irq_b from X1", irq_b, 1'b1);

        // R10/R2 low address bits ignored
        rd(SA, 4'hB, 32'hA5A50F0F, "R10 low addr bits ignored");

        // R5 owner clears
        wr(SA, 4'h4, 32'h00);
        chk("R5 irq_b after owner clear", irq_b, 1'b0);
        wr(SB, 4'hC, 32'h00);
        rd(SB, 4'hC, 32'h0, "R5 B owner clear");
        rd(SA, 4'h4, 32'h0, "R5 ctla all clear");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule